// File: doc/BRIEF.md
# Real-Time Clock Serial Command and Data Port

This block is the host-facing side of a real-time clock. A host selects the port with a chip-select line and then gives it commands in one of two ways. It can present a 3-bit code on parallel pins and pulse a strobe. It can also shift a 4-bit code in serially and then strobe a reserved parallel code that tells the port to take the serial one. The fourth command bit can only be reached through the serial path.

A single shift register of `DW` bits (48 by default) is used both to read the time and to set it. On a read command the port waits a fixed number of cycles and then copies a snapshot of the time counters into the register. The host then clocks the bits out, least-significant first. On a set command, the bits the host has already shifted in are offered to the counters together with a one-cycle preset pulse. While the port is waiting to take a snapshot, it drops a register-hold signal so that the counters can transfer. The serial output can show either the register contents or an external timing pulse. It is driven only while the port is selected.

All inputs are sampled on the system clock. The strobe and the serial clock act on their rising and falling edges as seen in that domain.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset, `mode` is 0, `reg_hold` is 1, `preset_pulse` is 0 and the serial register is all zeros. With `cs` low, `sdo_oe` and `sdo` are 0.
- R2: A rising edge of `stb` seen while `cs` is 1 and no read is pending loads `mode` with {0, `cmd_code`}, provided `cmd_code` is not 7. The new mode is visible from the cycle after the edge is sampled.
- R3: A strobe with `cmd_code` equal to 7 loads `mode` from the top four register bits. The first of the last four bits shifted in becomes `mode[0]`, and the last one becomes `mode[3]`.
- R4: While `cs` is 0, `stb` and `sclk` edges have no effect on `mode`, the register or `preset_pulse`, and both `sdo_oe` and `sdo` are 0.
- R5: On each rising `sclk` edge with `cs` high, the register shifts one place towards bit 0 and `sdi` enters at the top bit. After `DW` edges, the first bit sent sits in bit 0 of `preset_data`.
- R6: A strobe that yields a mode whose low three bits are 2 raises `preset_pulse` for exactly one cycle, with `preset_data` holding the shifted-in word.
- R7: A strobe that yields a mode whose low three bits are 3 loads `cnt_snap` into the register `RD_DLY` cycles after the strobe edge. Until the load, `reg_hold` is 0 and `sclk` and `stb` edges are ignored.
- R8: After the read load, `sdo` shows bit 0 of the snapshot. Each following rising then falling `sclk` pair advances `sdo` to the next bit, and `sdo` changes only on the falling edge.
- R9: When `mode[2]` is 1 and `cs` is 1, `sdo` follows `tp_in` instead of the register.
- R10: `reg_hold` is 1 at every time other than a pending read, including during a preset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| stb | input | 1 | Command strobe, rising edge acts |
| cmd_code | input | 3 | Parallel command code |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| tp_in | input | 1 | Timing pulse from the clock core |
| cnt_snap | input | DW | Current counter contents |
| sdo | output | 1 | Serial data out, gated by select |
| sdo_oe | output | 1 | Output enable for `sdo` |
| preset_pulse | output | 1 | One-cycle counter load strobe |
| preset_data | output | DW | Register contents offered to the counters |
| reg_hold | output | 1 | Low while a read snapshot is pending |
| mode | output | 4 | Current command |

## Verification
A 48-bit alternating word is shifted in and preset. This shows that the bits are ordered least-significant first and are not reversed. A second, irregular snapshot is then read out bit by bit through a queue of expected bits, which tells an off-by-one shift apart from a wrong output edge. Strobes and serial clocks sent with select low must leave the preset word and the mode untouched. A serially entered code with its top bit set shows that the extended bit is reached only by the serial path and that the output switches to the timing pulse.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int unsigned CMD_W = 4;
  localparam logic [2:0] PAR_SERIAL = 3'd7;
  localparam logic [2:0] OP_SET     = 3'd2;
  localparam logic [2:0] OP_READ    = 3'd3;

  function automatic logic [CMD_W-1:0] pick_mode(input logic [2:0] par,
                                                 input logic [CMD_W-1:0] ser);
    return (par == PAR_SERIAL) ? ser : {1'b0, par};
  endfunction

  function automatic logic is_set(input logic [CMD_W-1:0] m);
    return m[2:0] == OP_SET;
  endfunction

  function automatic logic is_read(input logic [CMD_W-1:0] m);
    return m[2:0] == OP_READ;
  endfunction

  function automatic logic uses_tp(input logic [CMD_W-1:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/rsp_edge.sv
module rsp_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= sig[g];
    end
    assign rise[g] = sig[g] & ~prev[g];
    assign fall[g] = ~sig[g] & prev[g];
  end
endmodule

// File: rtl/rsp_cmd.sv
module rsp_cmd
  import rsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [2:0]       par_code,
  input  logic [CMD_W-1:0] ser_code,
  output logic [CMD_W-1:0] mode,
  output logic             set_evt,
  output logic             read_evt
);
  logic [CMD_W-1:0] next_mode;

  assign next_mode = pick_mode(par_code, ser_code);
  assign set_evt   = take & is_set(next_mode);
  assign read_evt  = take & is_read(next_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode <= '0;
    else if (take) mode <= next_mode;
  end
endmodule

// File: rtl/rsp_shreg.sv
module rsp_shreg #(
  parameter int unsigned DW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          out_adv,
  output logic [DW-1:0] sh_q,
  output logic          out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else if (load_en) begin
      sh_q  <= load_val;
      out_q <= load_val[0];
    end else begin
      if (shift_en) sh_q  <= {sdi, sh_q[DW-1:1]};
      if (out_adv)  out_q <= sh_q[0];
    end
  end
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rsp_pkg::*;
#(
  parameter int unsigned DW     = 48,
  parameter int unsigned RD_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             stb,
  input  logic [2:0]       cmd_code,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             tp_in,
  input  logic [DW-1:0]    cnt_snap,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             preset_pulse,
  output logic [DW-1:0]    preset_data,
  output logic             reg_hold,
  output logic [CMD_W-1:0] mode
);
  localparam int unsigned CNT_W = $clog2(RD_DLY + 1);

  logic [1:0]       rise_w, fall_w;
  logic             stb_take_w, sclk_rise_w, sclk_fall_w;
  logic             shift_w, adv_w, load_w, busy_w;
  logic             set_evt_w, read_evt_w;
  logic [CNT_W-1:0] wait_cnt;
  logic [DW-1:0]    sh_q;
  logic             out_q;

  rsp_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({sclk, stb}),
    .rise (rise_w),
    .fall (fall_w)
  );

  assign busy_w      = (wait_cnt != '0);
  assign load_w      = (wait_cnt == CNT_W'(1));
  assign stb_take_w  = cs & rise_w[0] & ~busy_w;
  assign sclk_rise_w = cs & rise_w[1];
  assign sclk_fall_w = cs & fall_w[1];
  assign shift_w     = sclk_rise_w & ~busy_w;
  assign adv_w       = sclk_fall_w & ~busy_w;

  rsp_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (stb_take_w),
    .par_code(cmd_code),
    .ser_code(sh_q[DW-1 -: CMD_W]),
    .mode    (mode),
    .set_evt (set_evt_w),
    .read_evt(read_evt_w)
  );

  rsp_shreg #(.DW(DW)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_w),
    .sdi     (sdi),
    .load_en (load_w),
    .load_val(cnt_snap),
    .out_adv (adv_w),
    .sh_q    (sh_q),
    .out_q   (out_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt     <= '0;
      preset_pulse <= 1'b0;
    end else begin
      preset_pulse <= set_evt_w;
      if (read_evt_w)  wait_cnt <= CNT_W'(RD_DLY);
      else if (busy_w) wait_cnt <= wait_cnt - CNT_W'(1);
    end
  end

  assign preset_data = sh_q;
  assign reg_hold    = ~busy_w;
  assign sdo_oe      = cs;
  assign sdo         = cs & (uses_tp(mode) ? tp_in : out_q);
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int unsigned DW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          preset_pulse,
  input logic          reg_hold,
  input logic [3:0]    mode,
  input logic          shift_w,
  input logic [DW-1:0] sh_q
);
  AST_OE_OFF_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!sdo_oe && !sdo)); // R4
  AST_MODE_KEPT_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(mode)); // R4
  AST_PRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    preset_pulse |=> !preset_pulse); // R6
  AST_WAIT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hold |-> (mode[2:0] == 3'd3)); // R7
  AST_WAIT_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hold |=> $stable(mode)); // R7
  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_w |=> (sh_q[DW-2:0] == $past(sh_q[DW-1:1]))); // R5
  AST_HOLD_AT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    preset_pulse |-> reg_hold); // R10
endmodule

bind rtc_serial_port rsp_checker #(.DW(DW)) u_rsp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs          (cs),
  .sdo         (sdo),
  .sdo_oe      (sdo_oe),
  .preset_pulse(preset_pulse),
  .reg_hold    (reg_hold),
  .mode        (mode),
  .shift_w     (shift_w),
  .sh_q        (sh_q)
);

// File: tb/test_rtc_serial_port.sv
module test_rtc_serial_port;
  localparam int DW = 48;
  localparam int RD_DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, stb = 1'b0, sclk = 1'b0, sdi = 1'b0, tp_in = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [DW-1:0] cnt_snap = '0;
  logic sdo, sdo_oe, preset_pulse, reg_hold;
  logic [DW-1:0] preset_data;
  logic [3:0] mode;

  int errors = 0;
  int checks = 0;
  logic exp_q[$];

  always #4 clk = ~clk;

  rtc_serial_port #(.DW(DW), .RD_DLY(RD_DLY)) i_rtc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .stb(stb), .cmd_code(cmd_code),
    .sclk(sclk), .sdi(sdi), .tp_in(tp_in), .cnt_snap(cnt_snap),
    .sdo(sdo), .sdo_oe(sdo_oe), .preset_pulse(preset_pulse),
    .preset_data(preset_data), .reg_hold(reg_hold), .mode(mode)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe_on(input logic [2:0] code);
    cmd_code = code; stb = 1'b1; tick(); stb = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sclk = 1'b1; tick(); tick(); sclk = 1'b0; tick(); tick();
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    for (int i = 0; i < DW; i++) send_bit(w[i]);
  endtask

  // driver side of the scoreboard: expected read-out order
  task automatic push_word(input logic [DW-1:0] w);
    for (int i = 0; i < DW; i++) exp_q.push_back(w[i]);
  endtask

  // monitor side: compare the current output against the oldest expectation
  task automatic pop_and_compare();
    logic e;
    e = exp_q.pop_front();
    check("R8 sdo bit", {47'd0, sdo}, {47'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] w_set, w_rd, w_cmd;
    w_set = 48'hAAAA_5555_A5A5;
    w_rd  = 48'h9C3E_07B1_64D2;
    w_cmd = '0; w_cmd[47:44] = 4'b1101;
    tick(); tick(); rst_n = 1'b1; tick();
    // R1 reset state
    check("R1 mode", DW'(mode), 0);
    check("R1 reg_hold", DW'(reg_hold), 1);
    check("R1 preset_pulse", DW'(preset_pulse), 0);
    check("R1 sdo_oe", DW'(sdo_oe), 0);
    check("R1 preset_data", preset_data, 0);

    // R2 parallel command
    cs = 1'b1; tick();
    strobe_on(3'd1);
    check("R2 mode after strobe", DW'(mode), 1);
    check("R2 sdo_oe with cs", DW'(sdo_oe), 1);
    tick();

    // R5 shift order, R6 preset
    send_word(w_set);
    check("R5 shifted word", preset_data, w_set);
    strobe_on(3'd2);
    check("R6 preset pulse high", DW'(preset_pulse), 1);
    check("R10 hold during preset", DW'(reg_hold), 1);
    check("R6 preset data", preset_data, w_set);
    tick();
    check("R6 preset pulse one cycle", DW'(preset_pulse), 0);

    // R4 deselected: strobe and sclk ignored
    cs = 1'b0; tick();
    strobe_on(3'd5);
    check("R4 no preset when deselected", DW'(preset_pulse), 0);
    tick();
    check("R4 mode kept", DW'(mode), 2);
    send_bit(1'b0); send_bit(1'b1);
    check("R4 register kept", preset_data, w_set);
    check("R4 sdo low", DW'(sdo), 0);

    // R7 read with delay, R8 read-out via scoreboard
    cs = 1'b1; cnt_snap = w_rd; tick();
    strobe_on(3'd3);
    check("R7 reg_hold low while pending", DW'(reg_hold), 0);
    check("R7 mode read", DW'(mode), 3);
    push_word(w_rd);
    repeat (RD_DLY + 1) tick();
    check("R10 reg_hold back high", DW'(reg_hold), 1);
    check("R7 snapshot loaded", preset_data, w_rd);
    cnt_snap = '0;
    pop_and_compare();
    for (int k = 1; k < DW; k++) begin
      sdi = 1'b0; sclk = 1'b1; tick(); tick();
      if (k == 1) check("R8 sdo unchanged on rising edge", DW'(sdo), DW'(w_rd[0]));
      sclk = 1'b0; tick(); tick();
      pop_and_compare();
    end

    // R3 serial command with extended bit, R9 timing pulse output
    send_word(w_cmd);
    strobe_on(3'd7);
    tick();
    check("R3 serial mode", DW'(mode), 13);
    tp_in = 1'b1; tick();
    check("R9 sdo follows tp high", DW'(sdo), 1);
    tp_in = 1'b0; tick();
    check("R9 sdo follows tp low", DW'(sdo), 0);
    check("R10 hold outside read", DW'(reg_hold), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule